// File: doc/BRIEF.md
# Scaled Shift-Add Execution Unit

This unit executes the three scaled-add integer operations of a 64-bit scalar core. Each one takes the second register operand, optionally narrows it to its low 32 bits with sign or zero fill, shifts it left by one to four places, and adds the first register operand. Compilers use this to form array element addresses from a base and an index in one operation. The unit decodes the 32-bit instruction word itself. Register reads, hazard handling and exceptions belong to the surrounding pipeline.

The result, the destination register number, a recognised flag and an optional 4-bit condition field are registered once, so the outputs reflect the input presented one clock edge earlier. The condition field is produced only when the record bit of the instruction is set. Its fourth bit is a copy of the summary-overflow bit that the pipeline supplies.

Top module: `ssa_unit`

## Requirements
- R1: An instruction is recognised when `insn[31:26]` equals 22 and `insn[8:1]` holds one of the three operation codes 8'h6E, 8'hAE or 8'hEE. `insn[25:21]` is the destination number, `insn[10:9]` is the scale field SH, and `insn[0]` is the record bit. `out_hit` and `out_rt` then report the instruction.
- R2: With code 8'h6E, `out_data` = (`opb` << (SH+1)) + `opa` modulo 2^64, with zeros filling the vacated low bits.
- R3: With code 8'hAE, the low 32 bits of `opb` are sign-extended to 64 bits before the shift, so the upper half is all ones when `opb[31]` is 1.
- R4: With code 8'hEE, the low 32 bits of `opb` are zero-extended to 64 bits before the shift.
- R5: The shift distance is SH+1, which covers 1 to 4 places. No encoding gives a shift of zero.
- R6: A recognised instruction with the record bit at 1 raises `out_cr_wr` and loads `out_cr`. With the record bit at 0, `out_cr_wr` stays low and `out_cr` keeps its previous value.
- R7: `out_cr` bits are {3: negative, 2: positive and nonzero, 1: zero, 0: `so_in`}. They are judged on the 64-bit result taken as a signed value.
- R8: A word with a different primary code, or with an unlisted operation code, leaves `out_hit` and `out_cr_wr` low. `out_data`, `out_rt` and `out_cr` keep their previous values.
- R9: While `in_valid` is low, nothing is recognised. `out_hit` and `out_cr_wr` stay low and the other outputs hold.
- R10: The outputs change only at the clock edge that samples a valid input. Between edges they keep their previous values.
- R11: A low `rst_n` at a clock edge clears every output to zero. The clear takes effect at that edge and not before it.
- R12: `opa` is used as given even when the first source field `insn[20:16]` is 0. Register 0 is not read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| insn | input | 32 | Instruction word |
| opa | input | 64 | Value of the first source register (addend) |
| opb | input | 64 | Value of the second source register (scaled operand) |
| so_in | input | 1 | Current summary-overflow bit |
| out_hit | output | 1 | Recognised instruction. Doubles as the result write enable |
| out_rt | output | 5 | Destination register number |
| out_data | output | 64 | Result |
| out_cr | output | 4 | Condition field {negative, positive, zero, summary overflow} |
| out_cr_wr | output | 1 | Condition field write enable |

## Verification
On every cycle the assertions check four things. A condition write never occurs without a recognised result. Exactly one of the three sign flags is set, and it agrees with the registered result. Every recognised output traces back to a valid word with the right primary code. The result minus the addend is always even, which shows the shift is never zero. Reset clearing is also checked at each edge. The exact arithmetic of each variant can only be shown by the bench's scenarios: the sign fill of the signed-word form, the distance for each scale value, the holding of outputs on rejected or idle cycles, and the one-edge latency. The bench computes these values from the operands.

// File: rtl/ssa_pkg.sv
// Package: shared encodings for the scaled shift-add unit.
// Assumes a 32-bit instruction word with bit 31 as the most significant bit.
package ssa_pkg;

    localparam int INSN_W   = 32;
    localparam int REG_W    = 5;
    localparam int SCALE_W  = 2;
    localparam int CR_W     = 4;

    // Field positions inside the instruction word
    localparam int OPC_HI   = 31;
    localparam int OPC_LO   = 26;
    localparam int DST_HI   = 25;
    localparam int DST_LO   = 21;
    localparam int SCL_HI   = 10;
    localparam int SCL_LO   = 9;
    localparam int SUB_HI   = 8;
    localparam int SUB_LO   = 1;
    localparam int REC_BIT  = 0;

    localparam logic [OPC_HI-OPC_LO:0] PRIMARY_CODE = 6'd22;
    localparam logic [SUB_HI-SUB_LO:0] SUB_FULL     = 8'h6E;
    localparam logic [SUB_HI-SUB_LO:0] SUB_SWORD    = 8'hAE;
    localparam logic [SUB_HI-SUB_LO:0] SUB_UWORD    = 8'hEE;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_FULL  = 2'd1,
        KIND_SWORD = 2'd2,
        KIND_UWORD = 2'd3
    } kind_e;

    typedef struct packed {
        logic                legal;
        kind_e               kind;
        logic [REG_W-1:0]    rt;
        logic [SCALE_W-1:0]  sh;
        logic                rec;
    } dec_t;

endpackage

// File: rtl/ssa_decode.sv
// Module: ssa_decode
// Splits the instruction word into destination, scale and record fields and
// classifies the operation. Purely combinational; it assumes the caller gates
// the result with its own valid strobe.
module ssa_decode
    import ssa_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);

    kind_e kind;

    // Classify the operation from the primary and sub-operation codes
    always_comb begin
        kind = KIND_NONE;
        if (insn[OPC_HI:OPC_LO] == PRIMARY_CODE) begin
            case (insn[SUB_HI:SUB_LO])
                SUB_FULL:  kind = KIND_FULL;
                SUB_SWORD: kind = KIND_SWORD;
                SUB_UWORD: kind = KIND_UWORD;
                default:   kind = KIND_NONE;
            endcase
        end
    end

    // Pack the decoded fields
    always_comb begin
        dec.legal = (kind != KIND_NONE);
        dec.kind  = kind;
        dec.rt    = insn[DST_HI:DST_LO];
        dec.sh    = insn[SCL_HI:SCL_LO];
        dec.rec   = insn[REC_BIT];
    end

endmodule

// File: rtl/ssa_scale_add.sv
// Module: ssa_scale_add
// Prepares the scaled operand (full width, sign-extended low half or
// zero-extended low half), shifts it left by scale+1 and adds the addend.
// It assumes XLEN is even. The sum wraps modulo 2^XLEN and no carry is kept.
module ssa_scale_add
    import ssa_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int SW   = SCALE_W
) (
    input  kind_e            kind,
    input  logic [SW-1:0]    sh,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output logic [XLEN-1:0]  sum
);

    localparam int HALF = XLEN / 2;
    localparam int NSH  = 1 << SW;

    logic [XLEN-1:0] ext;
    logic [XLEN-1:0] cand [NSH];

    // Extend the scaled operand according to the variant
    always_comb begin
        case (kind)
            KIND_SWORD: ext = {{HALF{opb[HALF-1]}}, opb[HALF-1:0]};
            KIND_UWORD: ext = {{HALF{1'b0}}, opb[HALF-1:0]};
            default:    ext = opb;
        endcase
    end

    // One fixed-shift candidate per scale value (distance g+1)
    for (genvar g = 0; g < NSH; g++) begin : g_shift
        assign cand[g] = ext << (g + 1);
    end

    // Select the candidate and add the addend
    always_comb begin
        sum = opa + cand[sh];
    end

endmodule

// File: rtl/ssa_cond.sv
// Module: ssa_cond
// Forms the 4-bit condition field from a result: negative, positive-nonzero,
// zero (signed view), and the summary-overflow bit passed through.
module ssa_cond
    import ssa_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] value,
    input  logic            so,
    output logic [CR_W-1:0] cr
);

    logic is_zero;
    logic is_neg;

    // Sign and zero detection
    always_comb begin
        is_zero = ~|value;
        is_neg  = value[XLEN-1];
        cr      = {is_neg, ~is_neg & ~is_zero, is_zero, so};
    end

endmodule

// File: rtl/ssa_unit.sv
// Module: ssa_unit (top)
// Scaled shift-add execution unit with one registered output stage.
// It assumes the pipeline supplies register values and the summary-overflow bit
// in the same cycle as the instruction. Rejected or idle cycles leave the data
// outputs holding and keep both write enables low.
module ssa_unit
    import ssa_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [INSN_W-1:0]   insn,
    input  logic [XLEN-1:0]     opa,
    input  logic [XLEN-1:0]     opb,
    input  logic                so_in,
    output logic                out_hit,
    output logic [REG_W-1:0]    out_rt,
    output logic [XLEN-1:0]     out_data,
    output logic [CR_W-1:0]     out_cr,
    output logic                out_cr_wr
);

    dec_t            dec;
    logic [XLEN-1:0] sum;
    logic [CR_W-1:0] cr_next;
    logic            take;

    ssa_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    ssa_scale_add #(.XLEN(XLEN), .SW(SCALE_W)) u_add (
        .kind (dec.kind),
        .sh   (dec.sh),
        .opa  (opa),
        .opb  (opb),
        .sum  (sum)
    );

    ssa_cond #(.XLEN(XLEN)) u_cond (
        .value (sum),
        .so    (so_in),
        .cr    (cr_next)
    );

    // Accept only a valid, recognised instruction
    always_comb begin
        take = in_valid & dec.legal;
    end

    // Output stage: clear on reset, load on accept, otherwise hold data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_hit   <= 1'b0;
            out_cr_wr <= 1'b0;
            out_rt    <= '0;
            out_data  <= '0;
            out_cr    <= '0;
        end else begin
            out_hit   <= take;
            out_cr_wr <= take & dec.rec;
            if (take) begin
                out_rt   <= dec.rt;
                out_data <= sum;
                if (dec.rec) begin
                    out_cr <= cr_next;
                end
            end
        end
    end

    // R6
    cr_wr_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr_wr |-> out_hit);

    // R7
    cr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr_wr |-> ($countones(out_cr[3:1]) == 1
                       && out_cr[1] == (out_data == '0)
                       && out_cr[3] == out_data[XLEN-1]));

    // R1
    hit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> ($past(in_valid) && $past(insn[OPC_HI:OPC_LO]) == PRIMARY_CODE));

    // R5
    nonzero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (((out_data - $past(opa)) & {{(XLEN-1){1'b0}}, 1'b1}) == '0));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_hit && !out_cr_wr && out_data == '0 && out_cr == '0));

endmodule

// File: tb/ssa_unit_tb.sv
// Bench for ssa_unit: a vector table walked by one loop, then directed cases.
module ssa_unit_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  NV         = 12;
    localparam logic [63:0] A1 = 64'h1234_5678_9abc_def0;
    localparam logic [63:0] A2 = 64'h0000_0000_0000_0100;
    localparam logic [63:0] B1 = 64'h8000_0000_fedc_ba98;
    localparam logic [63:0] B2 = 64'h7fff_ffff_1234_5678;

    localparam logic [7:0]  T_XO  [NV] = '{8'h6E, 8'h6E, 8'h6E, 8'h6E, 8'hAE, 8'hAE,
                                          8'hAE, 8'hEE, 8'hEE, 8'hEE, 8'h2E, 8'h6E};
    localparam logic [1:0]  T_SH  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd3,
                                          2'd2, 2'd0, 2'd3, 2'd1, 2'd1, 2'd2};
    localparam logic        T_RC  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
                                          1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic [4:0]  T_RT  [NV] = '{5'd3, 5'd7, 5'd31, 5'd0, 5'd12, 5'd5,
                                          5'd9, 5'd17, 5'd22, 5'd1, 5'd4, 5'd30};
    localparam logic [4:0]  T_RAF [NV] = '{5'd4, 5'd8, 5'd2, 5'd6, 5'd10, 5'd11,
                                          5'd13, 5'd14, 5'd15, 5'd16, 5'd18, 5'd0};
    localparam logic [63:0] T_A   [NV] = '{A1, A2, A1, A2, A1, A2, A1, A2, A1, A2, A1, A1};
    localparam logic [63:0] T_B   [NV] = '{B1, B2, B1, B2, B1, B2, B1, B1, B1, B2, B1, B2};
    localparam logic        T_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                          1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] insn;
    logic [63:0] opa, opb;
    logic        so_in;
    logic        out_hit, out_cr_wr;
    logic [4:0]  out_rt;
    logic [63:0] out_data;
    logic [3:0]  out_cr;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [63:0] exp_data;
    logic [4:0]  exp_rt;
    logic [3:0]  exp_cr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ssa_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .insn      (insn),
        .opa       (opa),
        .opb       (opb),
        .so_in     (so_in),
        .out_hit   (out_hit),
        .out_rt    (out_rt),
        .out_data  (out_data),
        .out_cr    (out_cr),
        .out_cr_wr (out_cr_wr)
    );

    function automatic logic [31:0] mk(logic [5:0] po, logic [4:0] rt, logic [4:0] raf,
                                       logic [1:0] sh, logic [7:0] xo, logic rc);
        return {po, rt, raf, 5'd9, sh, xo, rc};
    endfunction

    function automatic logic [63:0] model(logic [7:0] xo, logic [1:0] sh,
                                          logic [63:0] a, logic [63:0] b);
        logic [63:0] n;
        case (xo)
            8'hAE:   n = {{32{b[31]}}, b[31:0]};
            8'hEE:   n = {32'h0, b[31:0]};
            default: n = b;
        endcase
        return (n << (int'(sh) + 1)) + a;
    endfunction

    function automatic logic [3:0] mcr(logic [63:0] v, logic so);
        return {$signed(v) < 0, $signed(v) > 0, v == 64'h0, so};
    endfunction

    function automatic string req_of(logic [7:0] xo);
        case (xo)
            8'hAE:   return "R3";
            8'hEE:   return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; return at the next falling edge
    task automatic apply(logic v, logic [31:0] w, logic [63:0] a, logic [63:0] b, logic so);
        in_valid = v;
        insn     = w;
        opa      = a;
        opb      = b;
        so_in    = so;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; insn = '0; opa = '0; opb = '0; so_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11 hit", {63'h0, out_hit}, 64'h0);
        chk("R11 crwr", {63'h0, out_cr_wr}, 64'h0);
        chk("R11 data", out_data, 64'h0);
        chk("R11 rt/cr", {55'h0, out_rt, out_cr}, 64'h0);
        exp_data = '0; exp_rt = '0; exp_cr = '0;

        // Table walk: R1..R8, R12
        for (int i = 0; i < NV; i++) begin
            logic so;
            so = (i % 3 == 0);
            apply(1'b1, mk(6'd22, T_RT[i], T_RAF[i], T_SH[i], T_XO[i], T_RC[i]),
                  T_A[i], T_B[i], so);
            if (T_HIT[i]) begin
                exp_data = model(T_XO[i], T_SH[i], T_A[i], T_B[i]);
                exp_rt   = T_RT[i];
                if (T_RC[i]) exp_cr = mcr(exp_data, so);
            end
            chk(T_HIT[i] ? "R1 hit" : "R8 hit", {63'h0, out_hit}, {63'h0, T_HIT[i]});
            chk(T_HIT[i] ? (T_RAF[i] == 0 ? "R12 data" : {req_of(T_XO[i]), "/R5 data"})
                         : "R8 data", out_data, exp_data);
            chk(T_HIT[i] ? "R1 rt" : "R8 rt", {59'h0, out_rt}, {59'h0, exp_rt});
            chk("R6 crwr", {63'h0, out_cr_wr}, {63'h0, T_HIT[i] & T_RC[i]});
            chk("R7 cr", {60'h0, out_cr}, {60'h0, exp_cr});
        end

        // R8: wrong primary code
        apply(1'b1, mk(6'd31, 5'd2, 5'd1, 2'd1, 8'h6E, 1'b1), A1, B1, 1'b0);
        chk("R8 primary hit", {63'h0, out_hit}, 64'h0);
        chk("R8 primary crwr", {63'h0, out_cr_wr}, 64'h0);
        chk("R8 primary data", out_data, exp_data);

        // R9: valid low with a legal word
        apply(1'b0, mk(6'd22, 5'd2, 5'd1, 2'd1, 8'hEE, 1'b1), A2, B2, 1'b1);
        chk("R9 hit", {63'h0, out_hit}, 64'h0);
        chk("R9 crwr", {63'h0, out_cr_wr}, 64'h0);
        chk("R9 data/rt", {out_data[58:0], out_rt}, {exp_data[58:0], exp_rt});
        chk("R9 cr", {60'h0, out_cr}, {60'h0, exp_cr});

        // R7: zero result gives EQ, summary bit copied
        apply(1'b1, mk(6'd22, 5'd6, 5'd3, 2'd0, 8'h6E, 1'b1), 64'hffff_ffff_ffff_fffe,
              64'h1, 1'b1);
        chk("R7 zero data", out_data, 64'h0);
        chk("R7 zero cr", {60'h0, out_cr}, 64'h3);

        // R7: positive nonzero gives GT
        apply(1'b1, mk(6'd22, 5'd6, 5'd3, 2'd0, 8'h6E, 1'b1), 64'h5, 64'h1, 1'b0);
        chk("R7 pos data", out_data, 64'h7);
        chk("R7 pos cr", {60'h0, out_cr}, 64'h4);

        // R6: record bit clear keeps the previous condition field
        apply(1'b1, mk(6'd22, 5'd6, 5'd3, 2'd3, 8'hAE, 1'b0), 64'h0, 64'h8000_0000, 1'b1);
        chk("R3 sign fill", out_data, 64'hffff_fff8_0000_0000);
        chk("R6 cr hold", {59'h0, out_cr_wr, out_cr}, 64'h4);

        // R10: outputs do not move before the sampling edge
        in_valid = 1'b1;
        insn     = mk(6'd22, 5'd11, 5'd3, 2'd1, 8'hEE, 1'b1);
        opa      = A1;
        opb      = B1;
        so_in    = 1'b0;
        #1;
        chk("R10 before edge", out_data, 64'hffff_fff8_0000_0000);
        @(negedge clk);
        chk("R10 after edge", out_data, model(8'hEE, 2'd1, A1, B1));

        // R11: synchronous reset clears at the edge, not before
        rst_n = 1'b0;
        #1;
        chk("R11 sync hold", {63'h0, out_hit}, 64'h1);
        @(negedge clk);
        chk("R11 cleared", {out_data[57:0], out_rt, out_hit}, 64'h0);
        chk("R11 cleared cr", {59'h0, out_cr_wr, out_cr}, 64'h0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule